// File: doc/BRIEF.md
# Dual-Path Frame-Aligned Datapath Switch

This block steers a valid/ready stream through a chain of processing stages. Every stage owns two identical slots. One slot carries live traffic while the other sits idle and can be loaded with a new function. Between stages, a small FIFO decouples the result of one stage from the input of the next. The block only handles routing, frame counting and the switch sequence. What runs inside a slot, and how a slot is loaded, are handled outside the block.

A frame spans `FRAME_BITS` bits, which is `FRAME_BITS/DATA_W` beats, and the block counts beats into each stage. A switch request moves its stage from `SW_IDLE` to `SW_WAIT_CFG`. The stage keeps streaming until the standby slot reports that it is loaded (transition to `SW_DRAIN`). It then accepts the rest of the current frame, holds off the next frame, and waits until every beat given to the old slot has come back. Next comes `SW_RESET`, which holds the standby slot in reset for `RST_CYC` cycles. At the end of that state the route flips, a done pulse is emitted, and the stage returns to `SW_IDLE`. The new slot starts on the first beat of the next frame with no further command. Each stage runs its own sequence.

Top module: `dps_switch`

## Requirements
- R1: After reset, every stage reports slot 0 as active (`active_slot` bit s = 0). No `sw_done` is high, no `slot_rst` is high and `out_vld` is low.
- R2: Beats enter only the active slot of each stage. Results are taken only from the active slot. The output carries every input beat exactly once and in order.
- R3: A `sw_req` pulse is taken only while its stage is idle. A pulse that arrives during a switch in progress has no effect.
- R4: Bit 2s+k of `cfg_done` reports that slot k of stage s is loaded. While the standby slot's bit is low, the stage does not switch and traffic keeps flowing.
- R5: A switch lands on a frame boundary. When `sw_done[s]` rises, the number of beats accepted into stage s is a multiple of FRAME_BITS/DATA_W. `slot_sof[s]` is high exactly on the first beat of each frame.
- R6: Before the route flips, every beat given to the old slot has been returned by it.
- R7: The incoming slot sees `slot_rst` high for exactly `RST_CYC` consecutive cycles, once per switch, and receives no valid beat during that time.
- R8: The route flip and a one-cycle `sw_done[s]` pulse happen together. `active_slot[s]` toggles. The new slot then receives beats without any further command.
- R9: A stage that is waiting for its standby slot does not hold up a switch in another stage.
- R10: An inter-stage FIFO never holds more than `FIFO_DEPTH` entries and respects back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input beat valid |
| in_rdy | output | 1 | Input beat accepted |
| in_dat | input | DATA_W | Input beat data |
| out_vld | output | 1 | Output beat valid |
| out_rdy | input | 1 | Downstream ready |
| out_dat | output | DATA_W | Output beat data |
| sw_req | input | NSTAGE | Per-stage switch request pulse |
| cfg_done | input | 2*NSTAGE | Bit 2s+k: slot k of stage s is loaded |
| active_slot | output | NSTAGE | Active slot index per stage |
| sw_done | output | NSTAGE | One-cycle pulse when a stage has switched |
| slot_vld | output | 2*NSTAGE | Beat valid into slot 2s+k |
| slot_rdy | input | 2*NSTAGE | Slot 2s+k can take a beat |
| slot_dat | output | NSTAGE*DATA_W | Beat data into stage s slots |
| slot_sof | output | NSTAGE | First beat of a frame for stage s |
| slot_rst | output | 2*NSTAGE | Reset to slot 2s+k |
| res_vld | input | 2*NSTAGE | Result valid from slot 2s+k |
| res_rdy | output | 2*NSTAGE | Result accepted from slot 2s+k |
| res_dat | input | 2*NSTAGE*DATA_W | Result data from slot 2s+k |

## Verification
The overlap of interest is both stages running their drain and reset sequences in the same cycles. In that case stage two's drain depends on beats that stage one has not yet released. The bench issues both requests in one cycle with both standby slots already loaded, while the input and output keep a gapped, back-pressured traffic pattern. Each completion is then judged on its own terms. The bench checks the beat count at a frame multiple, that the old slot is fully drained, that the reset run is exactly `RST_CYC` long, and that the output frames stay uniform in path tag and unbroken in sequence.

// File: rtl/dps_pkg.sv
package dps_pkg;
    typedef enum logic [1:0] {
        SW_IDLE     = 2'd0,
        SW_WAIT_CFG = 2'd1,
        SW_DRAIN    = 2'd2,
        SW_RESET    = 2'd3
    } sw_state_t;
endpackage

// File: rtl/dps_fifo.sv
module dps_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_vld,
    output logic         wr_rdy,
    input  logic [W-1:0] wr_dat,
    output logic         rd_vld,
    input  logic         rd_rdy,
    output logic [W-1:0] rd_dat
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          wr_fire, rd_fire;

    always_comb begin
        wr_rdy  = (cnt_q != (AW+1)'(DEPTH));
        rd_vld  = (cnt_q != '0);
        rd_dat  = mem[rp_q];
        wr_fire = wr_vld && wr_rdy;
        rd_fire = rd_vld && rd_rdy;
    end

    always_ff @(posedge clk) begin
        if (wr_fire) mem[wp_q] <= wr_dat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_fire) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (rd_fire) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            unique case ({wr_fire, rd_fire})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R10: occupancy bounded by depth
    a_r10_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (AW+1)'(DEPTH));
    // R10: a full FIFO that is not read keeps its count
    a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == (AW+1)'(DEPTH)) && !rd_rdy |=> cnt_q == (AW+1)'(DEPTH));
endmodule

// File: rtl/dps_stage.sv
module dps_stage
    import dps_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int FRAME_BEATS = 4,
    parameter int RST_CYC     = 4,
    parameter int CNT_W       = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_vld,
    output logic                up_rdy,
    input  logic [DATA_W-1:0]   up_dat,
    output logic                dn_vld,
    input  logic                dn_rdy,
    output logic [DATA_W-1:0]   dn_dat,
    input  logic                req,
    input  logic [1:0]          cfg_ok,
    output logic [1:0]          slot_vld,
    input  logic [1:0]          slot_rdy,
    output logic [DATA_W-1:0]   slot_dat,
    output logic                slot_sof,
    output logic [1:0]          slot_rst,
    input  logic [1:0]          res_vld,
    output logic [1:0]          res_rdy,
    input  logic [2*DATA_W-1:0] res_dat,
    output logic                act,
    output logic                done
);
    localparam int BC_W = (FRAME_BEATS > 1) ? $clog2(FRAME_BEATS) : 1;
    localparam int RC_W = $clog2(RST_CYC + 1);

    sw_state_t         state_q, state_d;
    logic [BC_W-1:0]   beat_q;
    logic [CNT_W-1:0]  fly_q;
    logic [RC_W-1:0]   rcnt_q;
    logic              act_q, done_q;
    logic              accept, in_fire, out_fire, rst_last;

    // next-state process
    always_comb begin
        state_d  = state_q;
        rst_last = (rcnt_q == RC_W'(RST_CYC - 1));
        unique case (state_q)
            SW_IDLE:     if (req)            state_d = SW_WAIT_CFG;
            SW_WAIT_CFG: if (cfg_ok[~act_q]) state_d = SW_DRAIN;
            SW_DRAIN:    if (beat_q == '0 && fly_q == '0) state_d = SW_RESET;
            SW_RESET:    if (rst_last)       state_d = SW_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            beat_q  <= '0;
            fly_q   <= '0;
            rcnt_q  <= '0;
            act_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (in_fire)
                beat_q <= (beat_q == BC_W'(FRAME_BEATS - 1)) ? '0 : beat_q + 1'b1;
            unique case ({in_fire, out_fire})
                2'b10:   fly_q <= fly_q + 1'b1;
                2'b01:   fly_q <= fly_q - 1'b1;
                default: fly_q <= fly_q;
            endcase
            rcnt_q <= (state_q == SW_RESET) ? rcnt_q + 1'b1 : '0;
            done_q <= (state_q == SW_RESET) && rst_last;
            if ((state_q == SW_RESET) && rst_last) act_q <= ~act_q;
        end
    end

    // output process
    always_comb begin
        accept   = !((state_q == SW_RESET) || (state_q == SW_DRAIN && beat_q == '0));
        up_rdy   = accept && slot_rdy[act_q];
        in_fire  = up_vld && up_rdy;
        dn_vld   = res_vld[act_q];
        dn_dat   = act_q ? res_dat[2*DATA_W-1:DATA_W] : res_dat[DATA_W-1:0];
        out_fire = dn_vld && dn_rdy;
        slot_dat = up_dat;
        slot_sof = (beat_q == '0);
        act      = act_q;
        done     = done_q;
    end

    for (genvar k = 0; k < 2; k++) begin : g_slot
        assign slot_vld[k] = up_vld && accept && (act_q == 1'(k));
        assign slot_rst[k] = (state_q == SW_RESET) && (act_q != 1'(k));
        assign res_rdy[k]  = dn_rdy && (act_q == 1'(k));
    end

    // R2: at most one slot receives a beat
    a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_vld));
    // R7: a slot under reset gets no data
    a_r7_no_data_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld & slot_rst) == 2'b00);
    // R8: the route only flips together with the done pulse
    a_r8_flip_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> done_q);
    // R6: old slot drained before the flip
    a_r6_drained: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(fly_q == '0));
    // R5: flip lands on a frame boundary
    a_r5_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> beat_q == '0);
    // R4: no progress towards the flip without a loaded standby slot
    a_r4_wait_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_WAIT_CFG) && !cfg_ok[~act_q] |=> state_q == SW_WAIT_CFG);
endmodule

// File: rtl/dps_switch.sv
module dps_switch #(
    parameter int DATA_W     = 8,
    parameter int FRAME_BITS = 18800,
    parameter int NSTAGE     = 2,
    parameter int RST_CYC    = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_vld,
    output logic                         in_rdy,
    input  logic [DATA_W-1:0]            in_dat,
    output logic                         out_vld,
    input  logic                         out_rdy,
    output logic [DATA_W-1:0]            out_dat,
    input  logic [NSTAGE-1:0]            sw_req,
    input  logic [2*NSTAGE-1:0]          cfg_done,
    output logic [NSTAGE-1:0]            active_slot,
    output logic [NSTAGE-1:0]            sw_done,
    output logic [2*NSTAGE-1:0]          slot_vld,
    input  logic [2*NSTAGE-1:0]          slot_rdy,
    output logic [NSTAGE*DATA_W-1:0]     slot_dat,
    output logic [NSTAGE-1:0]            slot_sof,
    output logic [2*NSTAGE-1:0]          slot_rst,
    input  logic [2*NSTAGE-1:0]          res_vld,
    output logic [2*NSTAGE-1:0]          res_rdy,
    input  logic [2*NSTAGE*DATA_W-1:0]   res_dat
);
    localparam int FRAME_BEATS = FRAME_BITS / DATA_W;

    logic [NSTAGE-1:0] up_v, up_r, dn_v, dn_r;
    logic [DATA_W-1:0] up_d [NSTAGE];
    logic [DATA_W-1:0] dn_d [NSTAGE];

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        if (s == 0) begin : g_head
            assign up_v[0] = in_vld;
            assign up_d[0] = in_dat;
            assign in_rdy  = up_r[0];
        end else begin : g_link
            dps_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
                .clk(clk), .rst_n(rst_n),
                .wr_vld(dn_v[s-1]), .wr_rdy(dn_r[s-1]), .wr_dat(dn_d[s-1]),
                .rd_vld(up_v[s]),   .rd_rdy(up_r[s]),   .rd_dat(up_d[s])
            );
        end
        if (s == NSTAGE - 1) begin : g_tail
            assign out_vld = dn_v[s];
            assign out_dat = dn_d[s];
            assign dn_r[s] = out_rdy;
        end

        dps_stage #(
            .DATA_W(DATA_W), .FRAME_BEATS(FRAME_BEATS),
            .RST_CYC(RST_CYC), .CNT_W(CNT_W)
        ) stage_i (
            .clk(clk), .rst_n(rst_n),
            .up_vld(up_v[s]), .up_rdy(up_r[s]), .up_dat(up_d[s]),
            .dn_vld(dn_v[s]), .dn_rdy(dn_r[s]), .dn_dat(dn_d[s]),
            .req(sw_req[s]), .cfg_ok(cfg_done[2*s +: 2]),
            .slot_vld(slot_vld[2*s +: 2]), .slot_rdy(slot_rdy[2*s +: 2]),
            .slot_dat(slot_dat[s*DATA_W +: DATA_W]), .slot_sof(slot_sof[s]),
            .slot_rst(slot_rst[2*s +: 2]),
            .res_vld(res_vld[2*s +: 2]), .res_rdy(res_rdy[2*s +: 2]),
            .res_dat(res_dat[2*s*DATA_W +: 2*DATA_W]),
            .act(active_slot[s]), .done(sw_done[s])
        );
    end
endmodule

// File: tb/dps_switch_tb_top.sv
module dps_switch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FB = 4;      // beats per frame: 32 bits / 8
    localparam int RC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0, out_rdy = 1'b0;
    logic [7:0] in_dat = 8'h00;
    logic in_rdy, out_vld;
    logic [7:0] out_dat;
    logic [1:0] sw_req = 2'b00;
    logic [3:0] cfg_done = 4'b0000;
    logic [1:0] active_slot, sw_done, slot_sof;
    logic [3:0] slot_vld, slot_rdy, slot_rst, res_vld, res_rdy;
    logic [15:0] slot_dat;
    logic [31:0] res_dat;

    int total = 0, bad = 0, cyc = 0;
    int seq_in = 0, seq_out = 0, ofr = 0;
    logic [3:0] ftag = 4'h0, last_tag = 4'h0;
    int nin [4] = '{0, 0, 0, 0};
    int nout [4] = '{0, 0, 0, 0};
    int rrun [4] = '{0, 0, 0, 0};
    int pulses [4] = '{0, 0, 0, 0};
    int sbeats [2] = '{0, 0};
    int done_cnt [2] = '{0, 0};
    logic [1:0] exp_act = 2'b00;
    logic run = 1'b0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dps_switch #(.DATA_W(8), .FRAME_BITS(32), .NSTAGE(2), .RST_CYC(RC),
                 .FIFO_DEPTH(4), .CNT_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_rdy(in_rdy), .in_dat(in_dat),
        .out_vld(out_vld), .out_rdy(out_rdy), .out_dat(out_dat),
        .sw_req(sw_req), .cfg_done(cfg_done),
        .active_slot(active_slot), .sw_done(sw_done),
        .slot_vld(slot_vld), .slot_rdy(slot_rdy), .slot_dat(slot_dat),
        .slot_sof(slot_sof), .slot_rst(slot_rst),
        .res_vld(res_vld), .res_rdy(res_rdy), .res_dat(res_dat)
    );

    // slot models: one-beat register that tags the high nibble
    for (genvar i = 0; i < 4; i++) begin : g_model
        logic hv;
        logic [7:0] hd;
        assign slot_rdy[i] = !hv || res_rdy[i];
        assign res_vld[i]  = hv;
        assign res_dat[i*8 +: 8] = hd;
        always @(posedge clk) begin
            if (!rst_n || slot_rst[i]) hv <= 1'b0;
            else if (slot_vld[i] && slot_rdy[i]) begin
                hv <= 1'b1;
                hd <= slot_dat[(i/2)*8 +: 8] ^ (8'h10 << i);
            end else if (res_rdy[i]) hv <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stimulus driven away from the active edge
    always @(negedge clk) begin
        in_vld  = run && (cyc % 5 != 4);
        in_dat  = {4'h0, 4'(seq_in)};
        out_rdy = (cyc % 3 != 2);
    end

    // monitors
    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (in_vld && in_rdy) seq_in++;
            if (out_vld && out_rdy) begin
                chk(out_dat[3:0] == 4'(seq_out), "R2 order", out_dat[3:0], seq_out % 16);
                if (ofr == 0) ftag = out_dat[7:4];
                else chk(out_dat[7:4] == ftag, "R5 frame uniform tag", out_dat[7:4], ftag);
                last_tag = out_dat[7:4];
                ofr = (ofr == FB - 1) ? 0 : ofr + 1;
                seq_out++;
            end
            for (int s = 0; s < 2; s++) begin
                if (sw_done[s]) begin
                    chk(sbeats[s] % FB == 0, "R5 boundary at done", sbeats[s] % FB, 0);
                    chk(nin[2*s + exp_act[s]] == nout[2*s + exp_act[s]], "R6 drained",
                        nout[2*s + exp_act[s]], nin[2*s + exp_act[s]]);
                    exp_act[s] = ~exp_act[s];
                    chk(active_slot[s] == exp_act[s], "R8 flip with done", active_slot[s], exp_act[s]);
                    done_cnt[s]++;
                end
            end
            for (int i = 0; i < 4; i++) begin
                if (slot_vld[i] && slot_rdy[i]) begin
                    chk(active_slot[i/2] == 1'(i % 2), "R2 active target", i, 2*(i/2) + active_slot[i/2]);
                    chk(slot_sof[i/2] == (sbeats[i/2] % FB == 0), "R5 sof", slot_sof[i/2], sbeats[i/2] % FB == 0);
                    nin[i]++;
                    sbeats[i/2]++;
                end
                if (res_vld[i] && res_rdy[i]) nout[i]++;
                if (slot_rst[i]) begin
                    rrun[i]++;
                    if (slot_vld[i]) chk(1'b0, "R7 data during reset", 1, 0);
                end else if (rrun[i] != 0) begin
                    chk(rrun[i] == RC, "R7 reset length", rrun[i], RC);
                    pulses[i]++;
                    rrun[i] = 0;
                end
            end
        end
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_done(input int s, input int target);
        for (int k = 0; k < 2000; k++) begin
            if (done_cnt[s] >= target) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse_req(input logic [1:0] which);
        @(negedge clk);
        sw_req = which;
        @(negedge clk);
        sw_req = 2'b00;
    endtask

    initial begin
        int mark;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(active_slot == 2'b00, "R1 active", active_slot, 0);
        chk(sw_done == 2'b00, "R1 done", sw_done, 0);
        chk(slot_rst == 4'b0000, "R1 slot reset", slot_rst, 0);
        chk(!out_vld, "R1 out_vld", out_vld, 0);
        rst_n = 1'b1;
        run = 1'b1;
        repeat (40) @(negedge clk);

        // R4: stage 0 request with no loaded standby slot
        pulse_req(2'b01);
        mark = seq_out;
        // R9: stage 1 switches while stage 0 still waits
        cfg_done = 4'b1000;
        pulse_req(2'b10);
        repeat (10) @(negedge clk);
        pulse_req(2'b01);                 // R3: ignored, stage 0 busy
        wait_done(1, 1);
        repeat (60) @(negedge clk);
        chk(active_slot == 2'b10, "R9 stage1 switched alone", active_slot, 2);
        chk(done_cnt[0] == 0, "R4 no switch without load", done_cnt[0], 0);
        chk(seq_out > mark + 20, "R4 traffic continues", seq_out - mark, 21);

        cfg_done = 4'b1010;
        wait_done(0, 1);
        repeat (5) @(negedge clk);
        chk(active_slot == 2'b11, "R8 both switched", active_slot, 3);
        cfg_done = 4'b1111;
        repeat (100) @(negedge clk);
        chk(done_cnt[0] == 1, "R3 busy request ignored", done_cnt[0], 1);
        chk(done_cnt[1] == 1, "R3 single stage1 switch", done_cnt[1], 1);

        // both stages in the same cycle
        pulse_req(2'b11);
        wait_done(0, 2);
        wait_done(1, 2);
        repeat (30) @(negedge clk);
        chk(active_slot == 2'b00, "R9 joint switch", active_slot, 0);

        run = 1'b0;
        repeat (80) @(negedge clk);
        chk(seq_out == seq_in, "R2 no loss", seq_out, seq_in);
        chk(last_tag == 4'h5, "R8 final path tag", last_tag, 5);
        chk(nin[1] > 0 && nin[3] > 0, "R8 new slot starts", nin[1] + nin[3], 1);
        for (int i = 0; i < 4; i++)
            chk(pulses[i] == 1, "R7 one pulse per switch", pulses[i], 1);
        chk(seq_out > 100, "R10 stream through FIFO", seq_out, 101);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule